// File: doc/BRIEF.md
# Dual-Mode Character Write Port

This block is the host-facing write side of an eight-character display driver. It holds the eight six-bit character codes and offers a combinational read port to the scan logic. A host stores codes with an active-low write strobe, gated by an active-low chip select. Each write cycle latches a mode bit that picks how the target slot is chosen. In random-access mode the three address pins name the slot. In sequential mode an internal counter names it and then steps, so several drivers can share one bus as a chain.

In sequential mode the address pins take other roles. Pin 0 becomes a write enable for the chain. Pin 1 becomes an active-low clear that acts at once: it blanks every slot and rewinds the counter. Pin 2 becomes a "chain full" output, modelled here as a separate output and output enable. The strobe is brought into the system clock through two-flop synchronizers. A small state machine follows each write through four states. IDLE waits for the strobe to open. RA_ARMED holds a random-access write with its address latched. SA_ARMED holds an accepted sequential write. SA_SKIP holds a sequential write that was refused.

The transitions are as follows. IDLE goes to RA_ARMED, SA_ARMED or SA_SKIP when the strobe opens, according to the mode and the enable/full state. Each of the other three states returns to IDLE when the strobe closes.

Top module: `chr_write_port`

## Requirements
- R1: After reset every slot reads the blank code 6'b100000, busy is 0, full_oe is 0 and the counter is 0.
- R2: A write happens only while wr_n and cs_n are both low. A strobe with cs_n high changes nothing. Either pin may time the write.
- R3: In random-access mode (mode_in 0 when the strobe opens), the slot is the value of addr_in when the strobe opens. Later changes on addr_in do not redirect the write. The stored code is data_in as it stands when the strobe closes.
- R4: mode_in is taken afresh at the opening of every write: 0 gives random access and 1 gives sequential access.
- R5: In sequential mode with addr_in[0] high and full_o low, the code goes to the slot named by the counter. The counter then steps by one, so accepted writes fill slots 0,1,2,... in order.
- R6: A sequential write with addr_in[0] low stores nothing and leaves the counter unchanged.
- R7: full_o rises after eight accepted sequential writes and stays high until a clear. While it is high, sequential writes store nothing.
- R8: While the latched mode is sequential, addr_in[1] low clears at once: every slot becomes blank, the counter returns to 0 and full_o falls. While the latched mode is random access, addr_in[1] has no clearing effect.
- R9: full_oe rises when the first sequential write after a random-access one closes. It falls when a random-access write opens.
- R10: busy is high from the opening to the closing of an accepted write (any random-access write, or an accepted sequential write). It stays low for refused writes and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| wr_n | input | 1 | Active-low write strobe |
| cs_n | input | 1 | Active-low chip select |
| mode_in | input | 1 | Mode for this write: 0 random, 1 sequential |
| addr_in | input | 3 | Slot address. In sequential mode bit 0 is the chain enable, bit 1 the active-low clear and bit 2 unused |
| data_in | input | 6 | Character code |
| rd_addr | input | 3 | Scan read address |
| rd_data | output | 6 | Code stored at rd_addr |
| full_o | output | 1 | Chain-full flag, the counter overflow bit |
| full_oe | output | 1 | Output enable for the shared full pin |
| busy | output | 1 | Accepted write in progress |

## Verification
Random-access writes are run over all eight slots. The address pins switch to the complement of the address once the strobe has opened, which separates an address latched at the opening from one followed live, and a data code unique to each slot exposes any mis-steered store. Sequential runs fill the chain in order, with a write refused by a low enable placed in the middle. A later write then shows whether the counter slipped, and a ninth write after full shows whether the saturation gate holds. Clear pulses are applied under both latched modes, telling a live clear apart from one wrongly honoured in random-access mode. Writes that are timed by chip select, and strobes blocked by it, test the gating of the two strobe pins.

// File: rtl/chr_wr_pkg.sv
package chr_wr_pkg;

    typedef enum logic {
        MODE_RA = 1'b0,
        MODE_SA = 1'b1
    } wr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RA_ARMED = 2'd1,
        ST_SA_ARMED = 2'd2,
        ST_SA_SKIP  = 2'd3
    } wr_state_e;

endpackage

// File: rtl/cwp_sync.sv
module cwp_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= {STAGES{RST_VAL}};
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cwp_clr_sync.sv
module cwp_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic clr_n
);
    logic [STAGES-1:0] sr;

    // asserted at once, released on the clock
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-2:0], 1'b1};
        end
    end

    assign clr_n = sr[STAGES-1];
endmodule

// File: rtl/cwp_ctrl.sv
module cwp_ctrl
    import chr_wr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              finish,
    input  logic              mode_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              full_i,
    input  logic [ADDR_W-1:0] cnt_addr,
    output logic              mode_sa,
    output logic              busy,
    output logic              we,
    output logic              cnt_inc,
    output logic              full_oe,
    output logic [ADDR_W-1:0] waddr
);
    wr_state_e         state, nxt;
    wr_mode_e          mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic              oe_q;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!mode_in)
                        nxt = ST_RA_ARMED;
                    else if (addr_in[0] && !full_i)
                        nxt = ST_SA_ARMED;
                    else
                        nxt = ST_SA_SKIP;
                end
            end
            ST_RA_ARMED, ST_SA_ARMED, ST_SA_SKIP: begin
                if (finish) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and opening/closing captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= MODE_RA;
            addr_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                mode_q <= wr_mode_e'(mode_in);
                addr_q <= addr_in;
                if (!mode_in) oe_q <= 1'b0;
            end
            if (state != ST_IDLE && finish) begin
                oe_q <= (mode_q == MODE_SA);
            end
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        we      = 1'b0;
        cnt_inc = 1'b0;
        waddr   = addr_q;
        unique case (state)
            ST_RA_ARMED: begin
                busy = 1'b1;
                we   = finish;
            end
            ST_SA_ARMED: begin
                busy    = 1'b1;
                we      = finish;
                cnt_inc = finish;
                waddr   = cnt_addr;
            end
            ST_IDLE, ST_SA_SKIP: begin
                busy = 1'b0;
            end
            default: busy = 1'b0;
        endcase
    end

    assign mode_sa = (mode_q == MODE_SA);
    assign full_oe = oe_q;
endmodule

// File: rtl/cwp_counter.sv
module cwp_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt <= '0;
        end else if (inc && !cnt[CNT_W-1]) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cwp_store.sv
module cwp_store #(
    parameter int DATA_W = 6,
    parameter int SLOTS  = 8,
    localparam int ADDR_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] BLANK = {1'b1, {(DATA_W-1){1'b0}}};

    logic [SLOTS-1:0][DATA_W-1:0] mem;
    logic [SLOTS-1:0]             slot_we;

    for (genvar i = 0; i < SLOTS; i++) begin : g_dec
        assign slot_we[i] = we && (waddr == ADDR_W'(i));
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= BLANK;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_we[i]) mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/chr_write_port.sv
module chr_write_port #(
    parameter int DATA_W      = 6,
    parameter int SLOTS       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(SLOTS),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              mode_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_o,
    output logic              full_oe,
    output logic              busy
);
    logic              en_raw, en_s, en_d;
    logic              start, finish;
    logic              mode_sa, clr_raw_n, arst_n, clr_n;
    logic              mem_we, cnt_inc;
    logic [ADDR_W-1:0] waddr;
    logic [CNT_W-1:0]  cnt;

    // combined strobe: both pins low
    assign en_raw = !wr_n && !cs_n;

    cwp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (en_raw),
        .q     (en_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= en_s;
    end

    assign start  = en_s && !en_d;
    assign finish = !en_s && en_d;

    // clear pin only live while the latched mode is sequential
    assign clr_raw_n = !(mode_sa && !addr_in[1]);
    assign arst_n    = rst_n && clr_raw_n;

    cwp_clr_sync #(.STAGES(SYNC_STAGES)) u_clr (
        .clk    (clk),
        .arst_n (arst_n),
        .clr_n  (clr_n)
    );

    cwp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .finish   (finish),
        .mode_in  (mode_in),
        .addr_in  (addr_in),
        .full_i   (cnt[CNT_W-1]),
        .cnt_addr (cnt[ADDR_W-1:0]),
        .mode_sa  (mode_sa),
        .busy     (busy),
        .we       (mem_we),
        .cnt_inc  (cnt_inc),
        .full_oe  (full_oe),
        .waddr    (waddr)
    );

    cwp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .clr_n (clr_n),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    cwp_store #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_store (
        .clk   (clk),
        .clr_n (clr_n),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (data_in),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign full_o = cnt[CNT_W-1];
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker #(
    parameter int CNT_W  = 4,
    parameter int DATA_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              busy,
    input logic              mem_we,
    input logic              full_oe,
    input logic              mode_sa,
    input logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] BLANK = {1'b1, {(DATA_W-1){1'b0}}};

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[CNT_W-1] |-> (cnt[CNT_W-2:0] == '0));

    p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        $past(cnt[CNT_W-1]) |-> cnt[CNT_W-1]);

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

    p_blank_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (rd_data == BLANK));

    p_write_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_we));

    p_oe_sa_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full_oe |-> mode_sa);
endmodule

bind chr_write_port cwp_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .cnt     (cnt),
    .busy    (busy),
    .mem_we  (mem_we),
    .full_oe (full_oe),
    .mode_sa (mode_sa),
    .rd_data (rd_data)
);

// File: tb/tb_chr_write_port.sv
module tb_chr_write_port;
    localparam int CLK_P = 10;
    localparam logic [5:0] BLANK = 6'b100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1;
    logic       cs_n = 1'b0;
    logic       mode_in = 1'b0;
    logic [2:0] addr_in = 3'b010;
    logic [5:0] data_in = '0;
    logic [2:0] rd_addr = '0;
    logic [5:0] rd_data;
    logic       full_o, full_oe, busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] exp_mem [8];
    logic busy_mid, oe_mid;

    always #(CLK_P/2) clk = ~clk;

    chr_write_port dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .mode_in(mode_in),
        .addr_in(addr_in), .data_in(data_in), .rd_addr(rd_addr), .rd_data(rd_data),
        .full_o(full_o), .full_oe(full_oe), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // generic write: strobe opens with a_open, closes with a_close on the pins
    task automatic wr(input logic m, input logic [2:0] a_open, input logic [2:0] a_close,
                      input logic [5:0] d, input logic via_cs);
        @(negedge clk);
        mode_in = m; addr_in = a_open; data_in = d;
        if (via_cs) begin
            cs_n = 1'b1; wr_n = 1'b0;
            @(negedge clk);
            cs_n = 1'b0;
        end else begin
            wr_n = 1'b0;
        end
        idle(4);
        busy_mid = busy; oe_mid = full_oe;
        addr_in = a_close;
        if (via_cs) cs_n = 1'b1; else wr_n = 1'b1;
        idle(5);
        cs_n = 1'b0; wr_n = 1'b1;
        idle(1);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #1;
            chk(req, rd_data, exp_mem[i]);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) exp_mem[i] = BLANK;
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        check_all("R1");
        chk("R1 busy", busy, 0);
        chk("R1 oe", full_oe, 0);
        chk("R1 full", full_o, 0);

        // R2 chip select blocks the strobe
        @(negedge clk);
        cs_n = 1'b1; addr_in = 3'd5; data_in = 6'h2A; wr_n = 1'b0;
        idle(6);
        wr_n = 1'b1;
        idle(6);
        cs_n = 1'b0;
        idle(2);
        check_all("R2 cs blocked");
        // R2 chip select times the write
        wr(1'b0, 3'd5, 3'd5, 6'h2A, 1'b1);
        exp_mem[5] = 6'h2A;
        check_all("R2 cs timed");

        // R3 R10 random-access sweep with address moving after the opening
        for (int a = 0; a < 8; a++) begin
            logic [5:0] d;
            d = 6'((a * 7 + 3) & 63);
            wr(1'b0, 3'(a), ~3'(a), d, 1'b0);
            exp_mem[a] = d;
            chk("R10 busy ra", busy_mid, 1);
        end
        check_all("R3");
        chk("R9 oe ra", full_oe, 0);
        chk("R10 idle", busy, 0);

        // R5 R9 sequential fill with a refused write (R6) in the middle
        for (int k = 0; k < 8; k++) begin
            logic [5:0] d;
            d = 6'(32 + k * 3);
            wr(1'b1, 3'b011, 3'b011, d, 1'b0);
            exp_mem[k] = d;
            if (k == 0) begin
                chk("R9 oe before close", oe_mid, 0);
                chk("R9 oe after close", full_oe, 1);
            end
            chk("R10 busy sa", busy_mid, 1);
            if (k == 2) begin
                wr(1'b1, 3'b010, 3'b010, 6'h15, 1'b0);
                chk("R6 busy refused", busy_mid, 0);
                check_all("R6");
            end
            chk("R7 full not yet", full_o, (k == 7) ? 1 : 0);
        end
        check_all("R5");
        // R7 write when full stores nothing
        wr(1'b1, 3'b011, 3'b011, 6'h3F, 1'b0);
        chk("R7 busy full", busy_mid, 0);
        check_all("R7");
        chk("R7 full held", full_o, 1);

        // R4 R9 mode back to random access per write
        wr(1'b0, 3'd6, 3'd6, 6'h05, 1'b0);
        exp_mem[6] = 6'h05;
        chk("R9 oe drop at open", oe_mid, 0);
        check_all("R4");

        // R8 clear pin ignored in random-access mode
        @(negedge clk);
        addr_in = 3'b000;
        idle(4);
        addr_in = 3'b010;
        idle(2);
        check_all("R8 ra no clear");
        chk("R8 full kept", full_o, 1);

        // R8 clear in sequential mode (refused write latches the mode)
        wr(1'b1, 3'b010, 3'b010, 6'h01, 1'b0);
        @(negedge clk);
        addr_in = 3'b000;
        idle(3);
        addr_in = 3'b010;
        idle(3);
        for (int i = 0; i < 8; i++) exp_mem[i] = BLANK;
        check_all("R8 clear");
        chk("R8 full cleared", full_o, 0);
        // counter rewound: next accepted write lands in slot 0
        wr(1'b1, 3'b011, 3'b011, 6'h11, 1'b0);
        exp_mem[0] = 6'h11;
        check_all("R8 rewound");
        chk("R7 not full", full_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule